// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers the interrupt events of a serial peripheral into one level-sensitive interrupt line. Six hardware sources set sticky bits in a status register. Four of the sources are single-cycle pulses and two are conditions that stay high. A per-source enable register and a master enable bit decide whether any pending bit reaches the interrupt line. All three registers sit behind a simple 32-bit word interface. Reads return data combinationally from the address, and a write strobe updates a register at the next clock edge.

Software acknowledges an event by writing a 1 to its status bit. The write XORs the data into the status register, so a 1 flips the bit. A hardware set in the same cycle takes priority over the flip, so no event is lost. The interrupt output is a flop. It follows the register contents with one cycle of delay and does not change while the registers are idle.

Top module: `intr_stat_ctrl`

## Requirements
- R1: Registers are decoded at word-aligned byte offsets: master enable at 0x1C, status at 0x20, per-source enable at 0x28. Any other offset, including an unaligned one, reads as zero and ignores writes. Read data follows `reg_addr` in the same cycle.
- R2: Only these status and enable bits exist: bit 2 transmit empty, bit 3 transmit underrun, bit 4 receive full, bit 5 receive overrun, bit 6 transmit half empty, bit 8 receive not empty. Every other bit position of the status and enable registers reads 0.
- R3: A source input that is high at a clock edge sets its status bit, visible from the next cycle. The bit then stays set until software flips it.
- R4: A write to the status register XORs the write data, restricted to the bits of R2, into the register. A 1 flips a bit and a 0 leaves it unchanged.
- R5: When a hardware set and a software flip hit the same status bit at the same edge, the bit ends set.
- R6: The receive-full and receive-not-empty inputs are levels. Their status bits are set again at every edge while the input is high, so a clearing write has no lasting effect during that time.
- R7: A write to the per-source enable register stores the bits of R2. The master enable register keeps only bit 31, and its other bits read 0.
- R8: `irq_o` is registered. At each edge it takes the value "(status AND enable) is nonzero, and the master enable bit is 1", computed from the register contents held before that edge.
- R9: While the master enable bit is 0, `irq_o` is 0 in the following cycle whatever the status and enable contents.
- R10: While `rst_n` is low at a clock edge, all three registers and `irq_o` are cleared.
- R11: After two consecutive edges with no write and no source active, `irq_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Write strobe for the register interface |
| reg_addr | input | 8 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_tx_empty | input | 1 | Transmit register empty event (pulse) |
| ev_tx_underrun | input | 1 | Transmit underrun event (pulse) |
| lv_rx_full | input | 1 | Receive FIFO full condition (level) |
| ev_rx_overrun | input | 1 | Receive overrun event (pulse) |
| ev_tx_half | input | 1 | Transmit FIFO half empty event (pulse) |
| lv_rx_not_empty | input | 1 | Receive FIFO not empty condition (level) |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bench targets five corner cases. The first is a set event landing in the same cycle as a clearing write: a design that gives the write priority drops that event. The second is a write of 1 to a bit that is already clear: under plain write-one-to-clear the bit stays 0 instead of being set. The third is a clearing write while a level input is still high: if the clear sticks, the receive condition goes unreported. The fourth is the one-cycle lag of the interrupt flop and its gating by the master bit: a combinational or ungated output shows up one cycle early or fires while masked. The last is writes to unmapped or unaligned offsets and to unused bit positions: a design that aliases them corrupts live registers or reads back non-zero data.

// File: rtl/isc_pkg.sv
// Package: shared constants and types for the interrupt status controller.
// Assumes a 32-bit register word and byte addressing with word-aligned offsets.
package isc_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int NUM_SRC = 6;
    localparam int GIE_BIT = 31;

    localparam logic [ADDR_W-1:0] OFS_GIE  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_EN   = 8'h28;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_GIE  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_EN   = 2'd3
    } reg_sel_e;

    // Status bit position of source index idx (neighbouring software decodes these).
    function automatic int src_pos(input int idx);
        case (idx)
            0:       return 2;   // transmit empty
            1:       return 3;   // transmit underrun
            2:       return 4;   // receive full
            3:       return 5;   // receive overrun
            4:       return 6;   // transmit half empty
            default: return 8;   // receive not empty
        endcase
    endfunction

    // Mask of the implemented status/enable bits.
    function automatic logic [REG_W-1:0] valid_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            m[src_pos(i)] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] VMASK = valid_mask();

endpackage

// File: rtl/isc_decode.sv
// Module: isc_decode
// Turns a byte offset into a register select. Only exact word-aligned
// matches select a register; everything else selects nothing.
module isc_decode
    import isc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    // Purpose: compare the offset against the three implemented registers.
    always_comb begin
        if (addr_i == OFS_GIE) begin
            sel_o = SEL_GIE;
        end else if (addr_i == OFS_STAT) begin
            sel_o = SEL_STAT;
        end else if (addr_i == OFS_EN) begin
            sel_o = SEL_EN;
        end else begin
            sel_o = SEL_NONE;
        end
    end

endmodule

// File: rtl/isc_set_map.sv
// Module: isc_set_map
// Places each source input on its status bit position. Assumes the source
// vector is ordered as the package function src_pos lists it.
module isc_set_map
    import isc_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic [N_SRC-1:0] src_i,
    output logic [REG_W-1:0] set_o
);

    // Purpose: scatter source bits onto a register-wide set vector.
    always_comb begin
        set_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            set_o[src_pos(i)] = src_i[i];
        end
    end

endmodule

// File: rtl/isc_regs.sv
// Module: isc_regs
// Holds the status, per-source enable and master enable registers, and
// muxes read data. Status writes XOR in; hardware sets win over flips.
// Assumes set_i carries only implemented bit positions.
module isc_regs
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  reg_sel_e          sel_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [REG_W-1:0]  set_i,
    output logic [REG_W-1:0]  status_o,
    output logic [REG_W-1:0]  enable_o,
    output logic              gie_o,
    output logic [REG_W-1:0]  rdata_o
);

    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] enable_q;
    logic             gie_q;
    logic [REG_W-1:0] flip;
    logic [REG_W-1:0] status_d;

    // Purpose: next status value, software flip first and hardware set on top.
    always_comb begin
        flip     = (wr_en_i && sel_i == SEL_STAT) ? (wdata_i & VMASK) : '0;
        status_d = ((status_q ^ flip) | set_i) & VMASK;
    end

    // Purpose: register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
            gie_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            if (wr_en_i && sel_i == SEL_EN) begin
                enable_q <= wdata_i & VMASK;
            end
            if (wr_en_i && sel_i == SEL_GIE) begin
                gie_q <= wdata_i[GIE_BIT];
            end
        end
    end

    // Purpose: combinational read mux.
    always_comb begin
        rdata_o = '0;
        case (sel_i)
            SEL_GIE:  rdata_o[GIE_BIT] = gie_q;
            SEL_STAT: rdata_o = status_q;
            SEL_EN:   rdata_o = enable_q;
            default:  rdata_o = '0;
        endcase
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign gie_o    = gie_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i))); // R5

    AST_FLIP_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_i == SEL_STAT && set_i == '0)
        |=> (status_q == ($past(status_q) ^ ($past(wdata_i) & VMASK)))); // R4

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q | enable_q) & ~VMASK) == '0); // R2

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && enable_q == '0 && !gie_q)); // R10

endmodule

// File: rtl/isc_irq_out.sv
// Module: isc_irq_out
// Registers the interrupt request from the current register contents.
// Assumes its inputs are flop outputs, so the request lags them by one cycle.
module isc_irq_out
    import isc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] status_i,
    input  logic [REG_W-1:0] enable_i,
    input  logic             gie_i,
    output logic             irq_o
);

    logic irq_q;

    // Purpose: flop the masked, globally gated pending indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= (|(status_i & enable_i)) & gie_i;
        end
    end

    assign irq_o = irq_q;

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(gie_i)); // R9

    AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(|(status_i & enable_i))); // R8

endmodule

// File: rtl/intr_stat_ctrl.sv
// Module: intr_stat_ctrl
// Top of the interrupt status controller: decode, source mapping, register
// file and registered interrupt output. Assumes one write per cycle and
// synchronous inputs.
module intr_stat_ctrl
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ev_tx_empty,
    input  logic              ev_tx_underrun,
    input  logic              lv_rx_full,
    input  logic              ev_rx_overrun,
    input  logic              ev_tx_half,
    input  logic              lv_rx_not_empty,
    output logic              irq_o
);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] src_vec;
    logic [REG_W-1:0]   set_vec;
    logic [REG_W-1:0]   status;
    logic [REG_W-1:0]   enable;
    logic               gie;

    // Source order follows src_pos: index 0 is bit 2 ... index 5 is bit 8.
    assign src_vec = {lv_rx_not_empty, ev_tx_half, ev_rx_overrun,
                      lv_rx_full, ev_tx_underrun, ev_tx_empty};

    isc_decode u_decode (
        .addr_i (reg_addr),
        .sel_o  (sel)
    );

    isc_set_map #(.N_SRC(NUM_SRC)) u_set_map (
        .src_i (src_vec),
        .set_o (set_vec)
    );

    isc_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (reg_wr_en),
        .sel_i    (sel),
        .wdata_i  (reg_wdata),
        .set_i    (set_vec),
        .status_o (status),
        .enable_o (enable),
        .gie_o    (gie),
        .rdata_o  (reg_rdata)
    );

    isc_irq_out u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .enable_i (enable),
        .gie_i    (gie),
        .irq_o    (irq_o)
    );

    // Assertion support: history of idle edges since reset.
    logic quiet_d1;
    logic quiet_d2;

    // Purpose: track two consecutive edges without writes or source activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_d1 <= 1'b0;
            quiet_d2 <= 1'b0;
        end else begin
            quiet_d1 <= !reg_wr_en && (src_vec == '0);
            quiet_d2 <= quiet_d1;
        end
    end

    AST_IRQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_d2 |-> $stable(irq_o)); // R11

endmodule

// File: tb/intr_stat_ctrl_tb_top.sv
module intr_stat_ctrl_tb_top;

    localparam int CLK_P = 10;
    localparam logic [31:0] IMPL = 32'h0000_017C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        ev_tx_empty = 1'b0;
    logic        ev_tx_underrun = 1'b0;
    logic        lv_rx_full = 1'b0;
    logic        ev_rx_overrun = 1'b0;
    logic        ev_tx_half = 1'b0;
    logic        lv_rx_not_empty = 1'b0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit started = 0;

    // reference model state
    logic [31:0] m_stat = 0;
    logic [31:0] m_en = 0;
    logic        m_gie = 0;
    logic        m_irq = 0;

    always #(CLK_P/2) clk = ~clk;

    intr_stat_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_tx_empty(ev_tx_empty), .ev_tx_underrun(ev_tx_underrun),
        .lv_rx_full(lv_rx_full), .ev_rx_overrun(ev_rx_overrun),
        .ev_tx_half(ev_tx_half), .lv_rx_not_empty(lv_rx_not_empty),
        .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h1C:   return {m_gie, 31'b0};
            8'h20:   return m_stat;
            8'h28:   return m_en;
            default: return 32'h0;
        endcase
    endfunction

    // Reference model: evaluated at each rising edge from the stable inputs.
    always @(posedge clk) begin
        logic [31:0] setv;
        logic [31:0] flipv;
        logic        nirq;
        if (!rst_n) begin
            m_stat = 0; m_en = 0; m_gie = 0; m_irq = 0;
        end else begin
            nirq  = ((m_stat & m_en) != 0) && m_gie;
            setv  = 0;
            setv[2] = ev_tx_empty;  setv[3] = ev_tx_underrun; setv[4] = lv_rx_full;
            setv[5] = ev_rx_overrun; setv[6] = ev_tx_half;   setv[8] = lv_rx_not_empty;
            flipv = (reg_wr_en && reg_addr == 8'h20) ? (reg_wdata & IMPL) : 0;
            m_stat = ((m_stat ^ flipv) | setv) & IMPL;
            if (reg_wr_en && reg_addr == 8'h28) m_en = reg_wdata & IMPL;
            if (reg_wr_en && reg_addr == 8'h1C) m_gie = reg_wdata[31];
            m_irq = nirq;
        end
        started = 1;
    end

    // Per-clock comparison a quarter period after the edge.
    always @(posedge clk) begin
        #(CLK_P/4);
        if (started) begin
            chk(irq_o === m_irq, "R8 irq per-cycle", {31'b0, irq_o}, {31'b0, m_irq});
            chk(reg_rdata === model_read(reg_addr), "R1 readback per-cycle",
                reg_rdata, model_read(reg_addr));
        end
    end

    task automatic idle();
        reg_wr_en = 0; ev_tx_empty = 0; ev_tx_underrun = 0; ev_rx_overrun = 0;
        ev_tx_half = 0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        rd_chk(8'h1C, 0, "R10 gie after reset");
        rd_chk(8'h20, 0, "R10 status after reset");
        rd_chk(8'h28, 0, "R10 enable after reset");
        chk(irq_o === 1'b0, "R10 irq after reset", {31'b0, irq_o}, 0);
        rst_n = 1;
        @(negedge clk);

        // R3: pulse sets a sticky bit
        ev_tx_empty = 1;
        @(negedge clk);
        ev_tx_empty = 0;
        rd_chk(8'h20, 32'h4, "R3 tx empty set");
        repeat (3) @(negedge clk);
        rd_chk(8'h20, 32'h4, "R3 sticky");

        // R7 / R2: enable and master enable storage
        wr_reg(8'h28, 32'hFFFF_FFFF);
        rd_chk(8'h28, 32'h0000_017C, "R7 enable stores implemented bits");
        chk(irq_o === 1'b0, "R9 no irq with gie clear", {31'b0, irq_o}, 0);
        wr_reg(8'h1C, 32'hFFFF_FFFF);
        rd_chk(8'h1C, 32'h8000_0000, "R7 gie keeps bit 31 only");
        chk(irq_o === 1'b0, "R8 irq lags register by one cycle", {31'b0, irq_o}, 0);
        @(negedge clk);
        chk(irq_o === 1'b1, "R8 irq asserted", {31'b0, irq_o}, 1);

        // R9: master enable off masks output
        wr_reg(8'h1C, 32'h0);
        @(negedge clk);
        chk(irq_o === 1'b0, "R9 irq masked by gie", {31'b0, irq_o}, 0);

        // R4: XOR behaviour, R2 unused bits
        wr_reg(8'h20, 32'h4);
        rd_chk(8'h20, 32'h0, "R4 write one clears set bit");
        wr_reg(8'h20, 32'hFFFF_FE83);
        rd_chk(8'h20, 32'h0, "R2 unused bits stay zero");
        wr_reg(8'h20, 32'h10);
        rd_chk(8'h20, 32'h10, "R4 write one flips clear bit to set");
        wr_reg(8'h20, 32'h10);
        rd_chk(8'h20, 32'h0, "R4 flip back");

        // R5: set wins over a same-cycle flip
        @(negedge clk);
        ev_rx_overrun = 1;
        @(negedge clk);
        ev_rx_overrun = 0;
        rd_chk(8'h20, 32'h20, "R5 overrun set");
        @(negedge clk);
        ev_rx_overrun = 1; reg_wr_en = 1; reg_addr = 8'h20; reg_wdata = 32'h20;
        @(negedge clk);
        idle();
        rd_chk(8'h20, 32'h20, "R5 set wins over flip");

        // R6: level input re-sets its bit
        lv_rx_not_empty = 1;
        @(negedge clk);
        rd_chk(8'h20, 32'h120, "R6 level sets bit 8");
        wr_reg(8'h20, 32'h100);
        rd_chk(8'h20, 32'h120, "R6 clear does not stick while level high");
        lv_rx_not_empty = 0;
        wr_reg(8'h20, 32'h100);
        rd_chk(8'h20, 32'h20, "R6 clear after level drops");

        // R1: unmapped and unaligned offsets
        wr_reg(8'h24, 32'hFFFF_FFFF);
        wr_reg(8'h21, 32'hFFFF_FFFF);
        rd_chk(8'h24, 32'h0, "R1 unmapped reads zero");
        rd_chk(8'h21, 32'h0, "R1 unaligned reads zero");
        rd_chk(8'h20, 32'h20, "R1 status untouched by unmapped write");
        rd_chk(8'h28, 32'h17C, "R1 enable untouched by unmapped write");
        rd_chk(8'h1C, 32'h0, "R1 gie untouched by unmapped write");

        // R11: stable output while idle
        wr_reg(8'h1C, 32'h8000_0000);
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(irq_o === 1'b1, "R11 irq stable while idle", {31'b0, irq_o}, 1);
        end

        // random traffic, checked each cycle against the model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            reg_wr_en = ($urandom % 3) == 0;
            case ($urandom % 5)
                0: reg_addr = 8'h1C;
                1: reg_addr = 8'h20;
                2: reg_addr = 8'h28;
                3: reg_addr = 8'h24;
                default: reg_addr = 8'h22;
            endcase
            reg_wdata = $urandom;
            ev_tx_empty = ($urandom % 8) == 0;
            ev_tx_underrun = ($urandom % 8) == 0;
            lv_rx_full = ($urandom % 6) == 0;
            ev_rx_overrun = ($urandom % 8) == 0;
            ev_tx_half = ($urandom % 8) == 0;
            lv_rx_not_empty = ($urandom % 4) == 0;
        end
        @(negedge clk);
        idle(); lv_rx_full = 0; lv_rx_not_empty = 0;
        repeat (3) @(negedge clk);

        // R10: reset mid-run
        wr_reg(8'h1C, 32'h8000_0000);
        wr_reg(8'h28, 32'h17C);
        wr_reg(8'h20, 32'h4);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        rd_chk(8'h20, 0, "R10 status cleared by reset");
        rd_chk(8'h28, 0, "R10 enable cleared by reset");
        rd_chk(8'h1C, 0, "R10 gie cleared by reset");
        chk(irq_o === 1'b0, "R10 irq cleared by reset", {31'b0, irq_o}, 0);
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule